// File: doc/BRIEF.md
# Table-Driven Unit Router

This block is the routing stage of a node that has one upward consumer and several outbound links. Each incoming 72-bit unit carries an 8-bit header in its top byte and a 64-bit payload below it. If the header's destination field equals the node's own identifier, the unit goes to the upward port. Otherwise the destination indexes a writable routing table. The table entry names an outbound port and says whether the route is valid. The unit then leaves on that port.

The table can be rewritten while traffic flows, for example to move routes off a link that has failed. A per-port link-fail mask also blocks forwarding on its own, without any table change. A unit whose route is invalid, or whose route points at a failed link, is dropped, and an error strobe is raised for one cycle.

The route is decided when a unit is accepted and is stored with it in a one-unit holding register. Later table writes and mask changes do not move a unit that is already held. Each sink has its own valid/ready pair. The input is stalled while the held unit waits on its selected sink.

Top module: `route_stage`

## Requirements
- R1: After a synchronous active-low reset, `up_valid`, `fwd_valid` and `drop_err` are low, `in_ready` is high, and every table entry is invalid.
- R2: A unit whose destination equals `my_id` is delivered on the upward port with all 72 bits unchanged, whatever its message type and table entry.
- R3: A non-local unit whose table entry is valid and whose port is not failed appears on `fwd_valid[port]` only. At most one of `up_valid` and the `fwd_valid` bits is high in any cycle.
- R4: A non-local unit whose table entry is invalid is consumed without being output, and `drop_err` is high for exactly the cycle after its acceptance.
- R5: A non-local unit whose table entry names a port whose `link_fail` bit is set is dropped in the same way as in R4.
- R6: A table write becomes visible to units accepted in the next cycle. A unit accepted in the same cycle as the write is routed by the old entry.
- R7: A held unit keeps the route chosen at acceptance, even if its entry is rewritten or `link_fail` changes while it waits.
- R8: While the held unit's selected sink is not ready, `in_ready` is low and the outputs and unit data stay stable.
- R9: When the selected sink is ready, a new unit is accepted in the same cycle the held one leaves, giving one unit per cycle.
- R10: The destination is `in_unit[71:67]`. The message type is `in_unit[66:64]` and does not affect routing. The payload is `in_unit[63:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_id | input | 5 | This node's identifier, held static |
| in_valid | input | 1 | Incoming unit valid |
| in_ready | output | 1 | Incoming unit accepted when high with in_valid |
| in_unit | input | 72 | Header (top byte) and payload |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Destination entry to write |
| tbl_port | input | 2 | Outbound port stored in the entry |
| tbl_en | input | 1 | Entry valid bit stored |
| link_fail | input | 4 | One bit per outbound link; set means failed |
| up_valid | output | 1 | Local unit available |
| up_ready | input | 1 | Upward consumer ready |
| up_unit | output | 72 | Local unit |
| fwd_valid | output | 4 | Forwarded unit valid, one bit per link |
| fwd_ready | input | 4 | Link ready, one bit per link |
| fwd_unit | output | 72 | Forwarded unit |
| drop_err | output | 1 | One-cycle strobe per dropped unit |

## Verification
Directed traffic first sends units of mixed types to the node's own identifier, which separates local delivery from table lookup. It then sends units to each of the four programmed ports, which shows that each entry's port decode is kept apart from the others. Invalid entries and failed links are tried on their own, so that the two drop causes are told apart. A table write in the same cycle as acceptance, and a rewrite while a unit waits on a stalled link, separate the values sampled at acceptance from the live ones. A long randomized run with random readiness, mask changes and table writes is compared every clock against a behavioural model.

// File: rtl/route_pkg.sv
// Shared types for the routing stage.
// Assumes: nothing beyond IEEE 1800-2017.
package route_pkg;
    // Route outcome decided at acceptance.
    typedef enum logic [1:0] {
        RT_DROP  = 2'd0,
        RT_LOCAL = 2'd1,
        RT_FWD   = 2'd2
    } rt_kind_e;
endpackage

// File: rtl/route_table.sv
// Routing table: one entry per destination, each with a valid bit and a port.
// Writes are registered, so a read in the write cycle returns the old entry.
// Assumes: addresses are in range (ENTRIES is a power of two).
module route_table #(
    parameter int ENTRIES = 32,
    parameter int PORT_W  = 2,
    localparam int ADDR_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PORT_W-1:0] wr_port,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [PORT_W-1:0] rd_port
);
    logic              ent_valid [ENTRIES];
    logic [PORT_W-1:0] ent_port  [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        // Hold one entry; clear on reset, update on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[e] <= 1'b0;
                ent_port[e]  <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(e))) begin
                ent_valid[e] <= wr_valid;
                ent_port[e]  <= wr_port;
            end
        end
    end

    // Combinational read of the addressed entry.
    always_comb begin
        rd_valid = ent_valid[rd_addr];
        rd_port  = ent_port[rd_addr];
    end
endmodule

// File: rtl/route_decide.sv
// Route decision: local match first, then table validity, then link health.
// Assumes: link_fail is sampled in the same cycle as the lookup.
module route_decide
    import route_pkg::*;
#(
    parameter int NODE_W = 5,
    parameter int NPORTS = 4,
    localparam int PORT_W = $clog2(NPORTS)
) (
    input  logic [NODE_W-1:0] dest,
    input  logic [NODE_W-1:0] my_id,
    input  logic              ent_valid,
    input  logic [PORT_W-1:0] ent_port,
    input  logic [NPORTS-1:0] link_fail,
    output rt_kind_e          kind,
    output logic [PORT_W-1:0] port
);
    // Pick local, forward or drop with local delivery taking priority.
    always_comb begin
        port = ent_port;
        if (dest == my_id) begin
            kind = RT_LOCAL;
        end else if (!ent_valid || link_fail[ent_port]) begin
            kind = RT_DROP;
        end else begin
            kind = RT_FWD;
        end
    end
endmodule

// File: rtl/route_hold.sv
// One-unit holding stage with per-sink handshakes.
// Stores the unit together with its route, so the route is frozen at accept.
// Assumes: the sinks follow valid/ready; dropped units never enter the stage.
module route_hold
    import route_pkg::*;
#(
    parameter int UNIT_W = 72,
    parameter int NPORTS = 4,
    localparam int PORT_W = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [UNIT_W-1:0] in_unit,
    input  rt_kind_e          in_kind,
    input  logic [PORT_W-1:0] in_port,
    output logic              up_valid,
    input  logic              up_ready,
    output logic [NPORTS-1:0] fwd_valid,
    input  logic [NPORTS-1:0] fwd_ready,
    output logic [UNIT_W-1:0] held_unit,
    output logic              drop_err
);
    logic              h_v;
    rt_kind_e          h_kind;
    logic [PORT_W-1:0] h_port;
    logic              sel_rdy;
    logic              take;

    // Readiness of the sink the held unit is bound for.
    always_comb begin
        sel_rdy  = (h_kind == RT_LOCAL) ? up_ready : fwd_ready[h_port];
        in_ready = !h_v || sel_rdy;
        take     = in_valid && in_ready;
    end

    // Load a routed unit, retire a delivered one, and strobe drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_v       <= 1'b0;
            h_kind    <= RT_DROP;
            h_port    <= '0;
            held_unit <= '0;
            drop_err  <= 1'b0;
        end else begin
            drop_err <= take && (in_kind == RT_DROP);
            if (take && (in_kind != RT_DROP)) begin
                h_v       <= 1'b1;
                h_kind    <= in_kind;
                h_port    <= in_port;
                held_unit <= in_unit;
            end else if (h_v && sel_rdy) begin
                h_v <= 1'b0;
            end
        end
    end

    // Drive the upward valid from the held route.
    always_comb up_valid = h_v && (h_kind == RT_LOCAL);

    for (genvar p = 0; p < NPORTS; p++) begin : g_fv
        // Decode the held port into one valid per link.
        always_comb fwd_valid[p] = h_v && (h_kind == RT_FWD) && (h_port == PORT_W'(p));
    end
endmodule

// File: rtl/route_stage.sv
// Top of the routing stage: table lookup, decision and holding register.
// Header is the top byte of the unit: destination above, message type below.
// Assumes: my_id is static during operation.
module route_stage
    import route_pkg::*;
#(
    parameter int NODE_W = 5,
    parameter int TYPE_W = 3,
    parameter int PAY_W  = 64,
    parameter int NPORTS = 4,
    localparam int HDR_W   = NODE_W + TYPE_W,
    localparam int UNIT_W  = HDR_W + PAY_W,
    localparam int ENTRIES = 1 << NODE_W,
    localparam int PORT_W  = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NODE_W-1:0] my_id,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [UNIT_W-1:0] in_unit,
    input  logic              tbl_we,
    input  logic [NODE_W-1:0] tbl_addr,
    input  logic [PORT_W-1:0] tbl_port,
    input  logic              tbl_en,
    input  logic [NPORTS-1:0] link_fail,
    output logic              up_valid,
    input  logic              up_ready,
    output logic [UNIT_W-1:0] up_unit,
    output logic [NPORTS-1:0] fwd_valid,
    input  logic [NPORTS-1:0] fwd_ready,
    output logic [UNIT_W-1:0] fwd_unit,
    output logic              drop_err
);
    logic [NODE_W-1:0] dest;
    logic              ent_valid;
    logic [PORT_W-1:0] ent_port;
    rt_kind_e          kind;
    logic [PORT_W-1:0] port;
    logic [UNIT_W-1:0] held_unit;

    // Extract the destination field from the header.
    always_comb dest = in_unit[UNIT_W-1 -: NODE_W];

    route_table #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_addr  (tbl_addr),
        .wr_port  (tbl_port),
        .wr_valid (tbl_en),
        .rd_addr  (dest),
        .rd_valid (ent_valid),
        .rd_port  (ent_port)
    );

    route_decide #(.NODE_W(NODE_W), .NPORTS(NPORTS)) u_dec (
        .dest      (dest),
        .my_id     (my_id),
        .ent_valid (ent_valid),
        .ent_port  (ent_port),
        .link_fail (link_fail),
        .kind      (kind),
        .port      (port)
    );

    route_hold #(.UNIT_W(UNIT_W), .NPORTS(NPORTS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_unit   (in_unit),
        .in_kind   (kind),
        .in_port   (port),
        .up_valid  (up_valid),
        .up_ready  (up_ready),
        .fwd_valid (fwd_valid),
        .fwd_ready (fwd_ready),
        .held_unit (held_unit),
        .drop_err  (drop_err)
    );

    // Both sinks see the held unit; valids select the consumer.
    always_comb begin
        up_unit  = held_unit;
        fwd_unit = held_unit;
    end
endmodule

// File: rtl/route_stage_chk.sv
// Checker for route_stage, attached by bind below.
// Assumes: my_id is held constant by the environment.
module route_stage_chk #(
    parameter int NODE_W = 5,
    parameter int UNIT_W = 72,
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NODE_W-1:0] my_id,
    input logic              in_valid,
    input logic              in_ready,
    input logic              up_valid,
    input logic              up_ready,
    input logic [UNIT_W-1:0] up_unit,
    input logic [NPORTS-1:0] fwd_valid,
    input logic [NPORTS-1:0] fwd_ready,
    input logic [UNIT_W-1:0] fwd_unit,
    input logic              drop_err
);
    logic stall;
    // Held unit exists but its sink refuses it.
    always_comb stall = (up_valid && !up_ready) || ((fwd_valid & ~fwd_ready) != '0);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!up_valid && fwd_valid == '0 && !drop_err));

    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up_valid, fwd_valid}));

    p_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |-> (up_unit[UNIT_W-1 -: NODE_W] == my_id));

    p_fwd_not_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid != '0) |-> (fwd_unit[UNIT_W-1 -: NODE_W] != my_id));

    p_drop_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drop_err |-> $past(in_valid && in_ready));

    p_no_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !in_ready);

    p_stall_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(up_valid) && $stable(fwd_valid) && $stable(fwd_unit)));
endmodule

bind route_stage route_stage_chk #(.NODE_W(NODE_W), .UNIT_W(UNIT_W), .NPORTS(NPORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .my_id     (my_id),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .up_valid  (up_valid),
    .up_ready  (up_ready),
    .up_unit   (up_unit),
    .fwd_valid (fwd_valid),
    .fwd_ready (fwd_ready),
    .fwd_unit  (fwd_unit),
    .drop_err  (drop_err)
);

// File: tb/route_stage_test.sv
module route_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  my_id = 5'd7;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [71:0] in_unit = '0;
    logic        tbl_we = 1'b0;
    logic [4:0]  tbl_addr = '0;
    logic [1:0]  tbl_port = '0;
    logic        tbl_en = 1'b0;
    logic [3:0]  link_fail = '0;
    logic        up_valid;
    logic        up_ready = 1'b1;
    logic [71:0] up_unit;
    logic [3:0]  fwd_valid;
    logic [3:0]  fwd_ready = 4'hF;
    logic [71:0] fwd_unit;
    logic        drop_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // reference model state
    bit          m_v = 0;
    logic [71:0] m_unit = '0;
    bit          m_local = 0;
    int          m_port = 0;
    bit          m_drop = 0;
    bit          m_tv [32];
    int          m_tp [32];

    always #10 clk = ~clk;

    route_stage uut (
        .clk(clk), .rst_n(rst_n), .my_id(my_id),
        .in_valid(in_valid), .in_ready(in_ready), .in_unit(in_unit),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_port(tbl_port), .tbl_en(tbl_en),
        .link_fail(link_fail),
        .up_valid(up_valid), .up_ready(up_ready), .up_unit(up_unit),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_unit(fwd_unit),
        .drop_err(drop_err)
    );

    function automatic bit m_sel_rdy();
        return m_local ? up_ready : fwd_ready[m_port];
    endfunction

    function automatic bit m_in_ready();
        return !m_v || m_sel_rdy();
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Behavioural model advanced at each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_v = 0; m_drop = 0; m_local = 0; m_port = 0;
            for (int i = 0; i < 32; i++) begin m_tv[i] = 0; m_tp[i] = 0; end
        end else begin
            bit rdy;
            bit nd;
            int d;
            rdy = m_in_ready();
            nd = 0;
            if (m_v && m_sel_rdy()) m_v = 0;
            if (in_valid && rdy) begin
                d = int'(in_unit[71:67]);
                if (in_unit[71:67] == my_id) begin
                    m_v = 1; m_local = 1; m_unit = in_unit;
                end else if (!m_tv[d] || link_fail[m_tp[d]]) begin
                    nd = 1;
                end else begin
                    m_v = 1; m_local = 0; m_port = m_tp[d]; m_unit = in_unit;
                end
            end
            m_drop = nd;
            if (tbl_we) begin
                m_tv[tbl_addr] = tbl_en;
                m_tp[tbl_addr] = int'(tbl_port);
            end
        end
    end

    // Compare the design with the model away from the edge.
    always @(negedge clk) begin
        logic [3:0] exp_fv;
        exp_fv = (m_v && !m_local) ? (4'b0001 << m_port) : 4'b0000;
        chk(up_valid == (m_v && m_local), "R2 up_valid", 72'(up_valid), 72'(m_v && m_local));
        chk(fwd_valid == exp_fv, "R3 fwd_valid", 72'(fwd_valid), 72'(exp_fv));
        chk(drop_err == m_drop, "R4/R5 drop_err", 72'(drop_err), 72'(m_drop));
        chk(in_ready == m_in_ready(), "R8 in_ready", 72'(in_ready), 72'(m_in_ready()));
        if (m_v && m_local) chk(up_unit == m_unit, "R10 up_unit", up_unit, m_unit);
        if (m_v && !m_local) chk(fwd_unit == m_unit, "R10 fwd_unit", fwd_unit, m_unit);
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    // Offer one unit until accepted, then withdraw it.
    task automatic send(input logic [4:0] dest, input logic [2:0] typ, input logic [63:0] pay);
        in_valid = 1'b1;
        in_unit = {dest, typ, pay};
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        step();
        in_valid = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [1:0] p, input logic en);
        tbl_we = 1'b1; tbl_addr = a; tbl_port = p; tbl_en = en;
        step();
        tbl_we = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(!up_valid && fwd_valid == 0 && !drop_err && in_ready, "R1 reset outputs",
            72'({up_valid, fwd_valid, drop_err, in_ready}), 72'h1);
        step();
        // R1: table invalid after reset, so a remote unit drops
        send(5'd1, 3'd0, 64'h11);
        @(negedge clk);
        chk(drop_err == 1'b1, "R1 table cleared", 72'(drop_err), 72'h1);
        step();

        wr(5'd1, 2'd0, 1'b1);
        wr(5'd2, 2'd1, 1'b1);
        wr(5'd3, 2'd2, 1'b1);
        wr(5'd4, 2'd3, 1'b1);
        wr(5'd5, 2'd2, 1'b0);
        wr(5'd7, 2'd1, 1'b0);

        // R2: local delivery for every message type
        for (int t = 0; t < 8; t++) send(5'd7, 3'(t), 64'hA000 + 64'(t));
        // R3: each port in turn
        for (int d = 1; d <= 4; d++) begin
            send(5'(d), 3'd2, 64'hB000 + 64'(d));
            @(negedge clk);
            chk(fwd_valid == (4'b0001 << (d - 1)), "R3 port select",
                72'(fwd_valid), 72'(4'b0001 << (d - 1)));
            step();
        end
        // R4: invalid entry drops
        send(5'd5, 3'd1, 64'hC5);
        @(negedge clk);
        chk(drop_err && fwd_valid == 0 && !up_valid, "R4 invalid drop",
            72'({drop_err, fwd_valid, up_valid}), 72'h20);
        step();
        @(negedge clk);
        chk(!drop_err, "R4 one-cycle strobe", 72'(drop_err), 72'h0);
        // R5: failed link drops
        link_fail = 4'b0100;
        step();
        send(5'd3, 3'd4, 64'hD3);
        @(negedge clk);
        chk(drop_err && fwd_valid == 0, "R5 failed link drop",
            72'({drop_err, fwd_valid}), 72'h10);
        link_fail = 4'b0000;
        step();

        // R6: write in the acceptance cycle uses the old entry
        tbl_we = 1'b1; tbl_addr = 5'd1; tbl_port = 2'd3; tbl_en = 1'b1;
        send(5'd1, 3'd0, 64'hE1);
        tbl_we = 1'b0;
        @(negedge clk);
        chk(fwd_valid == 4'b0001, "R6 old entry in write cycle", 72'(fwd_valid), 72'h1);
        step();
        send(5'd1, 3'd0, 64'hE2);
        @(negedge clk);
        chk(fwd_valid == 4'b1000, "R6 new entry next cycle", 72'(fwd_valid), 72'h8);
        step();

        // R7/R8: held unit keeps its route under a rewrite and a link failure
        fwd_ready = 4'b0111;
        send(5'd1, 3'd3, 64'hF1);
        wr(5'd1, 2'd0, 1'b1);
        link_fail = 4'b1000;
        in_valid = 1'b1; in_unit = {5'd2, 3'd0, 64'hF2};
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(fwd_valid == 4'b1000, "R7 frozen route", 72'(fwd_valid), 72'h8);
            chk(!in_ready, "R8 stalled input", 72'(in_ready), 72'h0);
            chk(fwd_unit == {5'd1, 3'd3, 64'hF1}, "R8 stable data", fwd_unit, {5'd1, 3'd3, 64'hF1});
            step();
        end
        fwd_ready = 4'hF;
        link_fail = 4'b0000;
        @(negedge clk);
        // R9: held unit leaves and the next is taken in the same cycle
        chk(in_ready, "R9 same-cycle refill", 72'(in_ready), 72'h1);
        step();
        in_valid = 1'b0;
        @(negedge clk);
        chk(fwd_valid == 4'b0010, "R9 next unit out", 72'(fwd_valid), 72'h2);
        step();
        // R9: streaming at one unit per cycle
        in_valid = 1'b1;
        for (int k = 0; k < 6; k++) begin
            in_unit = {5'd2, 3'(k), 64'(k)};
            @(negedge clk);
            chk(in_ready, "R9 streaming", 72'(in_ready), 72'h1);
            step();
        end
        in_valid = 1'b0;
        step();

        // Randomized run compared against the model (R2..R10)
        for (int c = 0; c < 3000; c++) begin
            logic [4:0] dst;
            dst = ($urandom_range(0, 3) == 0) ? my_id : 5'($urandom_range(0, 9));
            in_valid = ($urandom_range(0, 3) != 0);
            in_unit = {dst, 3'($urandom), 32'($urandom), 32'($urandom)};
            up_ready = ($urandom_range(0, 3) != 0);
            fwd_ready = 4'($urandom);
            if ($urandom_range(0, 15) == 0) link_fail = 4'($urandom) & 4'($urandom);
            tbl_we = ($urandom_range(0, 7) == 0);
            tbl_addr = 5'($urandom_range(0, 9));
            tbl_port = 2'($urandom);
            tbl_en = ($urandom_range(0, 4) != 0);
            step();
        end
        in_valid = 1'b0; tbl_we = 1'b0;
        step(); step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule